// File: doc/BRIEF.md
# Synchronized GPIO Bank

The bank serves eight general-purpose pins through a byte-wide register port. Per pin, software picks the direction (input or output), the drive style (open-drain or push-pull) and two pull enables that leave the block as plain control bits for the pad ring. The pin controls are split over two register groups: group A carries pins 0 to 5 and group B carries pins 6 and 7. In group A the pins do not sit at consecutive bits.

Reading the data register returns, for each pin, the synchronized pad level when the pin is an input and the stored data value when it is an output. Writes to the data registers go to a staged copy. In the normal mode the pads follow the staged copy at once. In synchronized mode the pads keep their value until software sets a trigger bit. All eight pins then change on the same clock edge. Software must clear the trigger before it can fire again.

Top module: `gpio_sync_bank`

## Requirements
- R1: After reset the staged data reads 0xFF at offset 0x12 and 0x0F at offset 0x13. The direction, drive-type, pull-up, pull-down and sync registers all read 0. Every pin is an open-drain output holding 1, so pin_oe = 0, pin_out = 0, pull_up_en = 0 and pull_dn_en = 0.
- R2: The registers are laid out from offset 0x10 in A/B pairs: direction at 0x10/0x11 (1 = input), data at 0x12/0x13, drive type at 0x14/0x15 (1 = push-pull, 0 = open-drain), pull-up at 0x16/0x17, pull-down at 0x18/0x19, and sync at 0x1A (bit 0 = sync enable, bit 1 = trigger). In group A, pins 0-2 use bits 0-2 and pins 3-5 use bits 4-6. In group B, pins 6 and 7 use bits 0 and 1.
- R3: Reserved bits cannot be written. In the data registers they read 1 (group A bits 3 and 7, group B bits 2 and 3). Every other reserved bit reads 0, including bits 7:4 of all group B registers and bits 7:2 of the sync register.
- R4: An output pin set to push-pull has pin_oe = 1 and pin_out equal to its driven data. An open-drain output has pin_out = 0 and pin_oe = 1 only while its driven data is 0. An input pin has pin_oe = 0 and pin_out = 0.
- R5: pull_up_en and pull_dn_en show the pull register bits, mapped to pin order, from the clock edge that takes the write.
- R6: A data read of an input pin returns pin_in through two flops. A change made between two edges is visible in the read after the second edge. A data read of an output pin returns the staged value.
- R7: While sync is disabled, a data write reaches the pads on the same clock edge that takes the write.
- R8: While sync is enabled, data writes change the staged value, which reads back, but the driven pad data holds.
- R9: With sync enabled and the stored trigger at 0, a write of 1 to the trigger copies all eight staged values to the pads on that edge. Writing 1 again while the trigger is already 1 copies nothing. Writing 0 re-arms it.
- R10: When sync is disabled, the pads hold on the edge that takes that write and take the staged values on the following edge.
- R11: Writes to offsets outside 0x10-0x1A change nothing, and reads there return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe, one write per cycle |
| reg_addr | input | ADDR_W | Register offset for reads and writes |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr, combinational |
| pin_in | input | 8 | Pad levels seen from outside |
| pin_oe | output | 8 | Pad drive enable per pin |
| pin_out | output | 8 | Pad drive value per pin |
| pull_up_en | output | 8 | Pull-up enable per pin |
| pull_dn_en | output | 8 | Pull-down enable per pin |

## Verification
Two events can fall on the same clock edge.

- **Trigger firing while the staged copy changes.** A trigger write lands in the cycle right after a staged write. The pads must then show the value just staged, not an older one. A repeated trigger while the trigger is still 1 must leave the pads alone.
- **Sync being disabled while a staged value is pending.** The clearing write must leave the pads unchanged on its own edge. The pads must take the staged value exactly one edge later.

A bench model updated at every clock edge predicts the pad drive and pull outputs, and these are compared against the design on every cycle. Directed checks add fixed expected values at the edges listed above.

// File: rtl/gpio_sync_bank_pkg.sv
package gpio_sync_bank_pkg;

    localparam int NPIN  = 8;
    localparam int REG_W = 8;

    // fixed read value of reserved bits inside the data registers
    localparam logic [REG_W-1:0] DATA_FILL_A = 8'h88;
    localparam logic [REG_W-1:0] DATA_FILL_B = 8'h0C;

    typedef struct packed {
        logic [NPIN-1:0] dir;      // 1 = input
        logic [NPIN-1:0] otype;    // 1 = push-pull
        logic [NPIN-1:0] pull_up;
        logic [NPIN-1:0] pull_dn;
        logic            sync_en;
        logic            trig;
    } ctrl_t;

    typedef struct packed {
        logic [NPIN-1:0] staged;
        logic [NPIN-1:0] pad;
    } stage_t;

    // register group a pin belongs to: 0 = group A, 1 = group B
    function automatic logic pin_group(input int p);
        return (p >= 6);
    endfunction

    // bit position of a pin inside its group byte
    function automatic logic [2:0] pin_slot(input int p);
        if (p < 3)      return 3'(p);
        else if (p < 6) return 3'(p + 1);
        else            return 3'(p - 6);
    endfunction

    function automatic logic [NPIN-1:0] grp_mask(input logic g);
        logic [NPIN-1:0] m;
        m = '0;
        for (int p = 0; p < NPIN; p++)
            if (pin_group(p) == g) m[p] = 1'b1;
        return m;
    endfunction

    function automatic logic [REG_W-1:0] grp_pack(input logic [NPIN-1:0] v, input logic g);
        logic [REG_W-1:0] r;
        r = '0;
        for (int p = 0; p < NPIN; p++)
            if (pin_group(p) == g) r[pin_slot(p)] = v[p];
        return r;
    endfunction

    function automatic logic [NPIN-1:0] grp_unpack(input logic [REG_W-1:0] b, input logic g);
        logic [NPIN-1:0] v;
        v = '0;
        for (int p = 0; p < NPIN; p++)
            if (pin_group(p) == g) v[p] = b[pin_slot(p)];
        return v;
    endfunction

    function automatic logic [NPIN-1:0] grp_merge(input logic [NPIN-1:0] cur,
                                                  input logic [REG_W-1:0] b,
                                                  input logic g);
        return (cur & ~grp_mask(g)) | (grp_unpack(b, g) & grp_mask(g));
    endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] level
);
    logic [STAGES-1:0][WIDTH-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = din;
        for (int i = 1; i < STAGES; i++)
            chain_d[i] = chain_q[i-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign level = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_data_stage.sv
module gpio_data_stage
    import gpio_sync_bank_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NPIN-1:0] wr_mask,
    input  logic [NPIN-1:0] wr_val,
    input  logic            sync_on,
    input  logic            fire,
    output logic [NPIN-1:0] staged_q,
    output logic [NPIN-1:0] pad_q
);
    stage_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.staged = (st_q.staged & ~wr_mask) | (wr_val & wr_mask);
        if (!sync_on)
            st_d.pad = st_d.staged;     // pads follow the write directly
        else if (fire)
            st_d.pad = st_q.staged;     // whole bank moves on one edge
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{staged: '1, pad: '1};
        else        st_q <= st_d;
    end

    assign staged_q = st_q.staged;
    assign pad_q    = st_q.pad;
endmodule

// File: rtl/gpio_pad_drive.sv
module gpio_pad_drive
    import gpio_sync_bank_pkg::*;
(
    input  logic [NPIN-1:0] dir,
    input  logic [NPIN-1:0] otype,
    input  logic [NPIN-1:0] pad,
    output logic [NPIN-1:0] oe,
    output logic [NPIN-1:0] out
);
    for (genvar i = 0; i < NPIN; i++) begin : g_pin
        // push-pull drives the value; open-drain only pulls low
        assign oe[i]  = ~dir[i] & (otype[i] | ~pad[i]);
        assign out[i] = ~dir[i] & otype[i] & pad[i];
    end
endmodule

// File: rtl/gpio_reg_bank.sv
module gpio_reg_bank
    import gpio_sync_bank_pkg::*;
#(
    parameter int                ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    output logic [REG_W-1:0]  rdata,
    input  logic [NPIN-1:0]   staged,
    input  logic [NPIN-1:0]   in_level,
    output ctrl_t             ctrl,
    output logic              fire,
    output logic [NPIN-1:0]   data_mask,
    output logic [NPIN-1:0]   data_val
);
    localparam logic [ADDR_W-1:0] OFS_DIR_A  = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] OFS_DIR_B  = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] OFS_DAT_A  = ADDR_W'(2);
    localparam logic [ADDR_W-1:0] OFS_DAT_B  = ADDR_W'(3);
    localparam logic [ADDR_W-1:0] OFS_TYP_A  = ADDR_W'(4);
    localparam logic [ADDR_W-1:0] OFS_TYP_B  = ADDR_W'(5);
    localparam logic [ADDR_W-1:0] OFS_PU_A   = ADDR_W'(6);
    localparam logic [ADDR_W-1:0] OFS_PU_B   = ADDR_W'(7);
    localparam logic [ADDR_W-1:0] OFS_PD_A   = ADDR_W'(8);
    localparam logic [ADDR_W-1:0] OFS_PD_B   = ADDR_W'(9);
    localparam logic [ADDR_W-1:0] OFS_SYNC   = ADDR_W'(10);

    ctrl_t             st_d, st_q;
    logic [ADDR_W-1:0] off;
    logic              hit;
    logic [NPIN-1:0]   data_view;

    assign off = addr - BASE_ADDR;
    assign hit = (addr >= BASE_ADDR) && (off <= OFS_SYNC);

    always_comb begin
        st_d      = st_q;
        fire      = 1'b0;
        data_mask = '0;
        data_val  = '0;
        if (wr && hit) begin
            case (off)
                OFS_DIR_A: st_d.dir     = grp_merge(st_q.dir, wdata, 1'b0);
                OFS_DIR_B: st_d.dir     = grp_merge(st_q.dir, wdata, 1'b1);
                OFS_TYP_A: st_d.otype   = grp_merge(st_q.otype, wdata, 1'b0);
                OFS_TYP_B: st_d.otype   = grp_merge(st_q.otype, wdata, 1'b1);
                OFS_PU_A:  st_d.pull_up = grp_merge(st_q.pull_up, wdata, 1'b0);
                OFS_PU_B:  st_d.pull_up = grp_merge(st_q.pull_up, wdata, 1'b1);
                OFS_PD_A:  st_d.pull_dn = grp_merge(st_q.pull_dn, wdata, 1'b0);
                OFS_PD_B:  st_d.pull_dn = grp_merge(st_q.pull_dn, wdata, 1'b1);
                OFS_DAT_A: begin
                    data_mask = grp_mask(1'b0);
                    data_val  = grp_unpack(wdata, 1'b0);
                end
                OFS_DAT_B: begin
                    data_mask = grp_mask(1'b1);
                    data_val  = grp_unpack(wdata, 1'b1);
                end
                OFS_SYNC: begin
                    st_d.sync_en = wdata[0];
                    st_d.trig    = wdata[1];
                    // only a 0 -> 1 change of the stored trigger fires
                    fire         = wdata[1] & ~st_q.trig & st_q.sync_en;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ctrl = st_q;

    always_comb begin
        for (int p = 0; p < NPIN; p++)
            data_view[p] = st_q.dir[p] ? in_level[p] : staged[p];
    end

    always_comb begin
        rdata = '0;
        if (hit) begin
            case (off)
                OFS_DIR_A: rdata = grp_pack(st_q.dir, 1'b0);
                OFS_DIR_B: rdata = grp_pack(st_q.dir, 1'b1);
                OFS_DAT_A: rdata = grp_pack(data_view, 1'b0) | DATA_FILL_A;
                OFS_DAT_B: rdata = grp_pack(data_view, 1'b1) | DATA_FILL_B;
                OFS_TYP_A: rdata = grp_pack(st_q.otype, 1'b0);
                OFS_TYP_B: rdata = grp_pack(st_q.otype, 1'b1);
                OFS_PU_A:  rdata = grp_pack(st_q.pull_up, 1'b0);
                OFS_PU_B:  rdata = grp_pack(st_q.pull_up, 1'b1);
                OFS_PD_A:  rdata = grp_pack(st_q.pull_dn, 1'b0);
                OFS_PD_B:  rdata = grp_pack(st_q.pull_dn, 1'b1);
                OFS_SYNC:  rdata = {6'b0, st_q.trig, st_q.sync_en};
                default:   rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/gpio_sync_bank.sv
module gpio_sync_bank
    import gpio_sync_bank_pkg::*;
#(
    parameter int                ADDR_W      = 8,
    parameter logic [ADDR_W-1:0] BASE_ADDR   = 8'h10,
    parameter int                SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic [NPIN-1:0]   pin_in,
    output logic [NPIN-1:0]   pin_oe,
    output logic [NPIN-1:0]   pin_out,
    output logic [NPIN-1:0]   pull_up_en,
    output logic [NPIN-1:0]   pull_dn_en
);
    ctrl_t           ctrl;
    logic            fire;
    logic            sync_on;
    logic [NPIN-1:0] dir_vec;
    logic [NPIN-1:0] data_mask, data_val;
    logic [NPIN-1:0] staged_q, pad_q;
    logic [NPIN-1:0] in_level;

    gpio_in_sync #(.WIDTH(NPIN), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (pin_in),
        .level (in_level)
    );

    gpio_reg_bank #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (reg_wr),
        .addr      (reg_addr),
        .wdata     (reg_wdata),
        .rdata     (reg_rdata),
        .staged    (staged_q),
        .in_level  (in_level),
        .ctrl      (ctrl),
        .fire      (fire),
        .data_mask (data_mask),
        .data_val  (data_val)
    );

    assign sync_on = ctrl.sync_en;
    assign dir_vec = ctrl.dir;

    gpio_data_stage u_stage (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_mask  (data_mask),
        .wr_val   (data_val),
        .sync_on  (sync_on),
        .fire     (fire),
        .staged_q (staged_q),
        .pad_q    (pad_q)
    );

    gpio_pad_drive u_drive (
        .dir   (dir_vec),
        .otype (ctrl.otype),
        .pad   (pad_q),
        .oe    (pin_oe),
        .out   (pin_out)
    );

    assign pull_up_en = ctrl.pull_up;
    assign pull_dn_en = ctrl.pull_dn;
endmodule

// File: rtl/gpio_sync_bank_chk.sv
module gpio_sync_bank_chk
    import gpio_sync_bank_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic [NPIN-1:0] pin_oe,
    input logic [NPIN-1:0] pin_out,
    input logic [NPIN-1:0] dir_vec,
    input logic            sync_on,
    input logic            fire,
    input logic [NPIN-1:0] staged,
    input logic [NPIN-1:0] pad
);
    assert_high_needs_drive_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_out & ~pin_oe) == '0);

    assert_input_released_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_oe & dir_vec) == '0);

    assert_follow_staged_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !sync_on |=> pad == staged);

    assert_pads_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_on && !fire) |=> $stable(pad));

    assert_fire_loads_R9: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> pad == $past(staged));

    assert_fire_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> !fire);
endmodule

bind gpio_sync_bank gpio_sync_bank_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .pin_oe  (pin_oe),
    .pin_out (pin_out),
    .dir_vec (dir_vec),
    .sync_on (sync_on),
    .fire    (fire),
    .staged  (staged_q),
    .pad     (pad_q)
);

// File: tb/gpio_sync_bank_test.sv
module gpio_sync_bank_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_addr = 8'h00;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic [7:0] pin_in = 8'h00;
    logic [7:0] pin_oe, pin_out, pull_up_en, pull_dn_en;

    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    gpio_sync_bank uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_in(pin_in),
        .pin_oe(pin_oe), .pin_out(pin_out),
        .pull_up_en(pull_up_en), .pull_dn_en(pull_dn_en)
    );

    // ---------------- behavioural reference model ----------------
    bit m_dir[8], m_pp[8], m_pu[8], m_pd[8], m_data[8], m_pad[8];
    bit m_sen, m_trig;
    bit [7:0] seen_q[$];   // pin_in history, newest first

    // which pins live where: group A bits, group B bits
    int a_bits[6] = '{0, 1, 2, 4, 5, 6};
    int b_bits[2] = '{0, 1};

    function automatic void m_write_group(ref bit field[8], input bit grp, input bit [7:0] v);
        if (!grp) for (int k = 0; k < 6; k++) field[k]   = v[a_bits[k]];
        else      for (int k = 0; k < 2; k++) field[k+6] = v[b_bits[k]];
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int p = 0; p < 8; p++) begin
                m_dir[p] = 0; m_pp[p] = 0; m_pu[p] = 0; m_pd[p] = 0;
                m_data[p] = 1; m_pad[p] = 1;
            end
            m_sen = 0; m_trig = 0;
            seen_q = {8'h00, 8'h00};
        end else begin
            bit old_sen, fire_now;
            old_sen  = m_sen;
            fire_now = 0;
            seen_q.push_front(pin_in);
            void'(seen_q.pop_back());
            if (reg_wr) begin
                case (reg_addr)
                    8'h10: m_write_group(m_dir, 0, reg_wdata);
                    8'h11: m_write_group(m_dir, 1, reg_wdata);
                    8'h12: m_write_group(m_data, 0, reg_wdata);
                    8'h13: m_write_group(m_data, 1, reg_wdata);
                    8'h14: m_write_group(m_pp, 0, reg_wdata);
                    8'h15: m_write_group(m_pp, 1, reg_wdata);
                    8'h16: m_write_group(m_pu, 0, reg_wdata);
                    8'h17: m_write_group(m_pu, 1, reg_wdata);
                    8'h18: m_write_group(m_pd, 0, reg_wdata);
                    8'h19: m_write_group(m_pd, 1, reg_wdata);
                    8'h1A: begin
                        fire_now = reg_wdata[1] && !m_trig && m_sen;
                        m_trig   = reg_wdata[1];
                        m_sen    = reg_wdata[0];
                    end
                    default: ;
                endcase
            end
            if (!old_sen || fire_now)
                for (int p = 0; p < 8; p++) m_pad[p] = m_data[p];
        end
    end

    // compare drive and pull outputs on every clock
    always @(negedge clk) begin
        if (rst_n) begin
            bit [7:0] e_oe, e_out, e_pu, e_pd;
            for (int p = 0; p < 8; p++) begin
                if (m_dir[p])     begin e_oe[p] = 0; e_out[p] = 0; end
                else if (m_pp[p]) begin e_oe[p] = 1; e_out[p] = m_pad[p]; end
                else              begin e_oe[p] = !m_pad[p]; e_out[p] = 0; end
                e_pu[p] = m_pu[p];
                e_pd[p] = m_pd[p];
            end
            total++;
            if (pin_oe !== e_oe || pin_out !== e_out) begin
                bad++;
                $display("FAIL R4 model drive: oe=%h out=%h expected oe=%h out=%h",
                         pin_oe, pin_out, e_oe, e_out);
            end
            total++;
            if (pull_up_en !== e_pu || pull_dn_en !== e_pd) begin
                bad++;
                $display("FAIL R5 model pulls: up=%h dn=%h expected up=%h dn=%h",
                         pull_up_en, pull_dn_en, e_pu, e_pd);
            end
        end
    end

    // ---------------- directed helpers ----------------
    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic rd(input string tag, input logic [7:0] a, input logic [7:0] exp);
        reg_addr = a;
        #1;
        chk(tag, reg_rdata, exp);
    endtask

    bit finished = 0;

    initial begin
        #(20 * 200000);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd("R1 data A", 8'h12, 8'hFF);
        rd("R1 data B", 8'h13, 8'h0F);
        rd("R1 dir A", 8'h10, 8'h00);
        rd("R1 sync", 8'h1A, 8'h00);
        chk("R1 pin_oe", pin_oe, 8'h00);
        chk("R1 pin_out", pin_out, 8'h00);
        chk("R1 pulls", pull_up_en | pull_dn_en, 8'h00);

        // R2/R3 drive type and reserved bits
        wr(8'h14, 8'hFF);
        rd("R3 type A readback", 8'h14, 8'h77);
        chk("R4 push-pull A oe", pin_oe, 8'h3F);
        wr(8'h15, 8'hFF);
        rd("R3 type B readback", 8'h15, 8'h03);
        chk("R4 push-pull all out", pin_out, 8'hFF);

        // R7 immediate update and R2 pin mapping
        wr(8'h12, 8'h00);
        chk("R7 clear A", pin_out, 8'hC0);
        rd("R3 data A reserved ones", 8'h12, 8'h88);
        wr(8'h12, 8'h05);
        chk("R2 low group A bits", pin_out, 8'hC5);
        wr(8'h12, 8'h50);
        chk("R2 high group A bits", pin_out, 8'hE8);

        // R4 open-drain
        wr(8'h14, 8'h00);
        chk("R4 open-drain oe", pin_oe, 8'hD7);
        chk("R4 open-drain out", pin_out, 8'hC0);

        // R5 pulls
        wr(8'h16, 8'h41);
        chk("R5 pull-up A", pull_up_en, 8'h21);
        wr(8'h19, 8'h02);
        chk("R5 pull-down B", pull_dn_en, 8'h80);
        wr(8'h17, 8'hF1);
        chk("R5 pull-up B", pull_up_en, 8'h61);
        rd("R3 pull-up B upper", 8'h17, 8'h01);

        // R6 input synchronizer
        wr(8'h11, 8'h03);
        chk("R6 inputs released", pin_oe, 8'h17);
        pin_in = 8'h40;
        rd("R6 before edges", 8'h13, 8'h0C);
        @(negedge clk);
        rd("R6 after one edge", 8'h13, 8'h0C);
        @(negedge clk);
        rd("R6 after two edges", 8'h13, 8'h0D);
        wr(8'h11, 8'h00);
        pin_in = 8'h00;

        // R8 staged writes in sync mode
        wr(8'h14, 8'h77);
        wr(8'h12, 8'h00);
        wr(8'h13, 8'h00);
        chk("R7 all low", pin_out, 8'h00);
        wr(8'h1A, 8'h01);
        rd("R2 sync readback", 8'h1A, 8'h01);
        wr(8'h12, 8'h77);
        wr(8'h13, 8'h03);
        chk("R8 pads hold", pin_out, 8'h00);
        rd("R8 staged A", 8'h12, 8'hFF);
        rd("R8 staged B", 8'h13, 8'h0F);

        // R9 trigger
        wr(8'h1A, 8'h03);
        chk("R9 fire", pin_out, 8'hFF);
        rd("R9 trigger stored", 8'h1A, 8'h03);
        wr(8'h12, 8'h00);
        chk("R8 hold after fire", pin_out, 8'hFF);
        rd("R8 staged readback", 8'h12, 8'h88);
        wr(8'h1A, 8'h03);
        chk("R9 no refire", pin_out, 8'hFF);
        wr(8'h1A, 8'h01);
        chk("R9 rearm", pin_out, 8'hFF);
        wr(8'h1A, 8'h03);
        chk("R9 second fire", pin_out, 8'hC0);

        // R10 leaving sync mode
        wr(8'h12, 8'h77);
        chk("R8 pending", pin_out, 8'hC0);
        wr(8'h1A, 8'h00);
        chk("R10 hold on clearing edge", pin_out, 8'hC0);
        @(negedge clk);
        chk("R10 follow next edge", pin_out, 8'hFF);
        rd("R10 sync cleared", 8'h1A, 8'h00);

        // R11 outside the map
        wr(8'h1B, 8'hFF);
        wr(8'h0F, 8'hFF);
        wr(8'h20, 8'h00);
        rd("R11 dir untouched", 8'h10, 8'h00);
        rd("R11 data untouched", 8'h12, 8'hFF);
        rd("R11 unmapped read", 8'h1B, 8'h00);
        chk("R11 pads untouched", pin_out, 8'hFF);

        // R3 group B data upper bits ignored
        wr(8'h13, 8'hF0);
        rd("R3 data B reserved", 8'h13, 8'h0C);
        chk("R3 only pins 6,7 changed", pin_out, 8'h3F);

        @(negedge clk);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule